// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is the two-wire bus front end of a 16-bit port expander. It watches SCL and SDA and finds START, repeated START and STOP conditions. It acknowledges its own 7-bit device address and then moves bytes between the bus and a simple register-file port. A write transaction always opens with one byte that sets a stored register pointer. Every byte after that is written to the register the pointer selects. A read transaction carries no pointer byte: it streams data starting from wherever the pointer was left.

After each data byte, whether written or read, the pointer flips its lowest bit. Registers therefore come in low/high pairs: 0x00/0x01 input ports, 0x02/0x03 output ports, 0x06/0x07 configuration, and so on. A multi-byte transfer cycles inside its pair and never walks the whole address space. The two input-port addresses are served by the block itself, from a snapshot of `port_lo_i` and `port_hi_i` captured when a read address is acknowledged. All other addresses read through `reg_rdata`.

SDA is open-drain. The block only asserts `sda_oe` to pull the line low, and the pad logic around it forms the wired-AND with the bus.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A START or repeated START at any point aborts the current transfer and begins a new address byte. A STOP returns the block to idle and leaves the stored pointer unchanged.
- R2: When the first 7 bits after a START (MSB first) equal `DEV_ADDR`, SDA is pulled low through the ninth clock. Any other address gets no acknowledge, and the block drives nothing until the next START.
- R3: In a write transaction (R/W bit 0), the first byte after the address is stored as the pointer and is acknowledged.
- R4: Each later write byte is acknowledged and produces one single-cycle `reg_we` pulse. During that pulse `reg_addr` holds the pointer value and `reg_wdata` holds the byte.
- R5: After every data byte written or read, the pointer inverts its bit 0 only, so transfers wrap inside a low/high pair. The pointer keeps its value across transactions.
- R6: A read transaction (R/W bit 1) sends bytes MSB first, starting at the stored pointer. Pointer 0x00 returns the low input port, 0x01 returns the high input port, and any other pointer returns `reg_rdata` for `reg_addr` equal to the pointer.
- R7: Both input ports are sampled together when a read address is acknowledged. Changes on the port pins during the read do not alter the bytes returned.
- R8: After a read byte, a master ACK (SDA low on the ninth clock) makes the block send the next byte. A master NACK makes it release SDA and stay silent until the next START.
- R9: A pointer-setting write followed by a repeated START and a read returns data from the pointer just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must oversample SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| port_lo_i | input | 8 | Input port bits 7..0 |
| port_hi_i | input | 8 | Input port bits 15..8 |
| reg_addr | output | 8 | Register-file address: the write address during `reg_we`, otherwise the pointer |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Combinational read data for `reg_addr` |

## Verification
A wrong pointer shows on the first data byte after it: a write strobe names the wrong address, or a read returns a byte from the other half of a pair or from another pair. A pointer disturbed by a STOP or by an ignored address stays hidden until the next transaction touches it. A stuck bit counter or a wrong state shows within one byte, as a missing or misplaced acknowledge on the ninth clock, or as SDA driven while the master owns the line. A stale or torn port snapshot shows only when the pins change between the address ACK and the second read byte.

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] port_lo_i,
  input  logic [7:0] port_hi_i,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WR, S_RD} state_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  state_t     st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr, snap_lo, snap_hi, wa_q, wd_q;
  logic       rw, mack, we_q;

  wire scl = scl_s[1];
  wire sda = sda_s[1];
  wire start_ev = scl & scl_q & sda_q & ~sda;
  wire stop_ev  = scl & scl_q & ~sda_q & sda;
  wire rise = scl & ~scl_q;
  wire fall = ~scl & scl_q;
  wire addr_hit = (sh[7:1] == DEV_ADDR);
  wire [7:0] nxt_ptr = {ptr[7:1], ~ptr[0]};
  wire [7:0] rd_byte = (ptr == 8'h00) ? snap_lo :
                       (ptr == 8'h01) ? snap_hi : reg_rdata;

  assign reg_addr  = we_q ? wa_q : ptr;
  assign reg_we    = we_q;
  assign reg_wdata = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      snap_lo <= '0;
      snap_hi <= '0;
      wa_q    <= '0;
      wd_q    <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      we_q    <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_ev) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda};
          else if (cnt == 4'd8) mack <= ~sda;
          if (cnt < 4'd9) cnt <= cnt + 4'd1;
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_ADDR: begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  if (sh[0]) begin
                    snap_lo <= port_lo_i;
                    snap_hi <= port_hi_i;
                  end
                end else begin
                  st <= S_IDLE;
                end
              end
              S_CMD: begin
                ptr    <= sh;
                sda_oe <= 1'b1;
              end
              S_WR: begin
                we_q   <= 1'b1;
                wa_q   <= ptr;
                wd_q   <= sh;
                ptr    <= nxt_ptr;
                sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_ADDR: begin
                if (rw) begin
                  st     <= S_RD;
                  tx     <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  ptr    <= nxt_ptr;
                end else begin
                  st <= S_CMD;
                end
              end
              S_CMD: st <= S_WR;
              S_RD: begin
                if (mack) begin
                  tx     <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                  ptr    <= nxt_ptr;
                end else begin
                  st <= S_IDLE;
                end
              end
              default: ;
            endcase
          end else if (st == S_RD && cnt != 4'd0) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

  assert_stop_keeps_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (ptr == $past(ptr)));

  assert_idle_is_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_drive_on_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_pair_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (ptr == {reg_addr[7:1], ~reg_addr[0]}));

endmodule

// File: tb/i2c_ptr_slave_test.sv
module i2c_ptr_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] port_lo = 8'h00, port_hi = 8'h00;
  wire sda_oe, reg_we;
  wire [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] rf [0:255];
  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

  i2c_ptr_slave #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .port_lo_i(port_lo), .port_hi_i(port_hi), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_mem [0:255];
  logic [7:0] m_ptr = 8'h00;
  logic [7:0] m_snap_lo, m_snap_hi;
  logic [15:0] exp_wr [$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_wr.size() == 0) chk("R4 unexpected strobe", {reg_addr, reg_wdata}, 16'hxxxx);
      else chk("R4 write strobe", {reg_addr, reg_wdata}, exp_wr.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
    clk_bit(~master_ack, s);
  endtask

  function automatic logic [7:0] model_read();
    logic [7:0] r;
    r = (m_ptr == 8'h00) ? m_snap_lo : (m_ptr == 8'h01) ? m_snap_hi : m_mem[m_ptr];
    m_ptr[0] = ~m_ptr[0];
    return r;
  endfunction

  task automatic model_write(input logic [7:0] d);
    exp_wr.push_back({m_ptr, d});
    m_mem[m_ptr] = d;
    m_ptr[0] = ~m_ptr[0];
  endtask

  // write transaction: address, pointer byte, then n data bytes
  task automatic wr_txn(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input bit stop_end);
    logic ack;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start;
    put_byte({DEV, 1'b0}, ack); chk("R2 address ack (write)", ack, 1'b1);
    put_byte(cmd, ack);         chk("R3 pointer byte ack", ack, 1'b1);
    m_ptr = cmd;
    for (int i = 0; i < n; i++) begin
      model_write(d[i]);
      put_byte(d[i], ack); chk("R4 data byte ack", ack, 1'b1);
    end
    if (stop_end) bus_stop;
  endtask

  // read transaction of n bytes; optionally disturb the ports after the address
  task automatic rd_txn(input int n, input bit disturb, input string req);
    logic ack;
    logic [7:0] v, e;
    bus_start;
    m_snap_lo = port_lo; m_snap_hi = port_hi;
    put_byte({DEV, 1'b1}, ack); chk("R2 address ack (read)", ack, 1'b1);
    if (disturb) begin port_lo = ~port_lo; port_hi = ~port_hi; end
    for (int i = 0; i < n; i++) begin
      e = model_read();
      get_byte(i != n - 1, v);
      chk(req, v, e);
    end
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      rf[i] = 8'(i * 7 + 3);
      m_mem[i] = 8'(i * 7 + 3);
    end
    tick(5);
    chk("R1 reset sda_oe", sda_oe, 1'b0);
    chk("R4 reset reg_we", reg_we, 1'b0);
    rst_n = 1'b1;
    tick(5);

    // R3/R4/R5: pointer set, two writes wrap within output pair
    wr_txn(8'h02, 2, 8'hA5, 8'h5A, 8'h00, 1'b1);
    // R6/R5: read continues from persistent pointer (now 0x02)
    rd_txn(1, 0, "R6 read from stored pointer");
    // R5: three writes on 0x03 wrap 03,02,03
    wr_txn(8'h03, 3, 8'h11, 8'h22, 8'h33, 1'b1);
    rd_txn(2, 0, "R5 read wraps in pair");

    // R9: pointer write, repeated START, read two bytes of config pair
    wr_txn(8'h06, 2, 8'h3C, 8'hC3, 8'h00, 1'b1);
    wr_txn(8'h06, 0, 8'h00, 8'h00, 8'h00, 1'b0);
    rd_txn(2, 0, "R9 read after repeated START");

    // R7: input ports snapshot, pins change after the address ACK
    port_lo = 8'h81; port_hi = 8'h7E;
    wr_txn(8'h00, 0, 8'h00, 8'h00, 8'h00, 1'b0);
    rd_txn(2, 1, "R7 coherent port snapshot");
    port_lo = 8'h4B; port_hi = 8'hD2;
    wr_txn(8'h01, 0, 8'h00, 8'h00, 8'h00, 1'b0);
    rd_txn(2, 0, "R6 high port then low port");

    // R1: STOP right after pointer byte keeps pointer
    wr_txn(8'h07, 0, 8'h00, 8'h00, 8'h00, 1'b1);
    rd_txn(1, 0, "R1 pointer kept across STOP");
    rd_txn(1, 0, "R5 pointer wraps 07->06");

    // R2: foreign address ignored, nothing written, pointer unchanged
    bus_start;
    put_byte({7'h21, 1'b0}, ack); chk("R2 foreign address no ack", ack, 1'b0);
    put_byte(8'h02, ack);         chk("R2 ignored byte no ack", ack, 1'b0);
    put_byte(8'hEE, ack);         chk("R2 ignored byte no ack", ack, 1'b0);
    bus_stop;
    rd_txn(1, 0, "R2 pointer untouched by foreign address");

    // R1: repeated START aborts a write mid-stream, new pointer takes effect
    wr_txn(8'h04, 1, 8'h99, 8'h00, 8'h00, 1'b0);
    wr_txn(8'h08, 1, 8'h77, 8'h00, 8'h00, 1'b1);
    rd_txn(2, 0, "R1 repeated START restarts transfer");

    // R8: NACK ends the read; further clocks see a released line
    bus_start;
    m_snap_lo = port_lo; m_snap_hi = port_hi;
    put_byte({DEV, 1'b1}, ack); chk("R8 address ack", ack, 1'b1);
    get_byte(1'b0, v); chk("R8 byte before NACK", v, model_read());
    get_byte(1'b0, v); chk("R8 silent after NACK", v, 8'hFF);
    bus_stop;
    rd_txn(1, 0, "R8 pointer advanced once for NACKed read");

    tick(10);
    chk("R4 all expected writes seen", 16'(exp_wr.size()), 16'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule